// File: doc/BRIEF.md
# Block-Move DMA Address Generator

This block turns one block-move script instruction into the two values a DMA engine needs: a 24-bit byte count and a full 64-bit bus address. The caller hands over the first two instruction words, the script pointer already advanced past them and the data-structure base register, then pulses `start`. Depending on two flag bits in the first word and three mode enables, the block issues up to two dword reads on a single-outstanding memory-read port. The address can then be used as given, loaded through a pointer, fetched from a table relative to the base register, or completed by a third instruction word.

The upper 32 address bits come from a chain of sources. In 40-bit mode they are the top byte of the fetched table count. In table-indirect 64-bit mode that byte holds a 5-bit selector into sixteen scratch registers and six special selector registers. In the remaining cases they come from the dynamic selector register if it is nonzero, then from the static selector if that is nonzero, and are zero otherwise. The dynamic selector register lives in the block and is loaded by the direct 64-bit fetch. A selector that points nowhere raises a sticky error. The decode still finishes with a done pulse.

Top module: `bmove_addr_gen`

## Requirements
- R1: For direct, indirect and direct-64 forms `xfer_count` equals `instr_w0[23:0]`. For the table form it equals bits 23:0 of the first fetched table dword, and the table dword's bits 31:24 never reach the count.
- R2: With `instr_w0[28]` and `instr_w0[29]` both clear and `mode_d64` low, the low address word equals `instr_w1` and no memory read is issued.
- R3: With `instr_w0[29]` set and `instr_w0[28]` clear, exactly one read is issued at address `instr_w1`, and the returned dword becomes the low address word.
- R4: With `instr_w0[28]` set, `instr_w1[23:0]` is sign-extended and added to `dsa_base`. Reads go to that sum and then to the sum plus 4, and the second dword is the low address word. This form takes precedence over bit 29 and over `mode_d64`.
- R5: In the table form with `mode_40` high, the upper word is the zero-extended bits 31:24 of the first table dword. `mode_40` takes precedence over `mode_ti64`. In non-table forms, either of these modes forces the upper word to zero.
- R6: In the table form with `mode_ti64` high and `mode_40` low, selector = table dword bits 28:24. Values 0..15 pick `scratch_vec` slot N (bits 32N+31:32N). Values 0x10..0x15 pick, in this order, `mm_rd_sel`, `mm_wr_sel`, `fetch_sel`, `dsa_rel_sel`, `static_sel` and the dynamic selector register.
- R7: A selector above 0x15 sets `sel_err`, forces the upper word to zero and still ends with a done pulse. `sel_err` holds until the next accepted `start` and is cleared in the cycle after it.
- R8: With `mode_d64` high and bits 28 and 29 clear, one read is issued at `script_ptr_in` and its data loads the dynamic selector (`dyn_sel`). `script_ptr_out` becomes `script_ptr_in + 4`, and `instr_addr` becomes `script_ptr_out - 12`.
- R9: In every other form `script_ptr_out` equals `script_ptr_in` and `instr_addr` equals `script_ptr_in - 8`.
- R10: Without 40-bit or table-64 addressing in effect, the upper word is `dyn_sel` if nonzero, else `static_sel` if nonzero, else zero. `dyn_sel` keeps its value across decodes.
- R11: `mem_req` stays high with `mem_addr` unchanged until `mem_valid`, and only one read is outstanding. `done` is a single-cycle pulse that arrives after the last read.
- R12: After reset all outputs and `dyn_sel` are zero. Results change only at the `done` pulse and are held, whatever the inputs do, until the next decode completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (accepted when not busy) |
| instr_w0 | input | 32 | First instruction word: count and form flags |
| instr_w1 | input | 32 | Second instruction word: address, pointer or table offset |
| script_ptr_in | input | 32 | Script pointer after the two instruction words |
| dsa_base | input | 32 | Data-structure base for table addressing |
| mode_40 | input | 1 | 40-bit addressing enable |
| mode_ti64 | input | 1 | Table-indirect 64-bit selector enable |
| mode_d64 | input | 1 | Direct 64-bit third-word enable |
| scratch_vec | input | 512 | Sixteen scratch registers, slot N at bits 32N+31:32N |
| mm_rd_sel | input | 32 | Memory-move read selector (code 0x10) |
| mm_wr_sel | input | 32 | Memory-move write selector (code 0x11) |
| fetch_sel | input | 32 | Script fetch selector (code 0x12) |
| dsa_rel_sel | input | 32 | Base-relative selector (code 0x13) |
| static_sel | input | 32 | Static block-move selector (code 0x14, fallback) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 32 | Read data |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| xfer_count | output | 24 | Transfer byte count |
| dma_addr | output | 64 | Full DMA address |
| instr_addr | output | 32 | Address of the decoded instruction |
| script_ptr_out | output | 32 | Script pointer after the instruction |
| dyn_sel | output | 32 | Dynamic selector register (code 0x15) |
| sel_err | output | 1 | Sticky illegal-selector flag |

## Verification
Some properties are checked on every cycle: the request stays held with a steady address until data returns, and `done` is one cycle wide with no request beside it. The results hold still between completions, the gap between pointer and instruction address is 8 or 12, an error completion carries a zero upper word, and the error clears after a start. Which source feeds the upper word can only be shown by the bench's scenarios. The same goes for the sign of the table offset, the precedence between forms and modes, the number of reads per form, and the value the dynamic selector carries from one decode to the next. The bench sweeps all 32 selector codes against independently computed expectations.

// File: rtl/bmag_pkg.sv
package bmag_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_FETCH_PTR  = 3'd1,
      ST_FETCH_TBL0 = 3'd2,
      ST_FETCH_TBL1 = 3'd3,
      ST_FETCH_HI   = 3'd4,
      ST_DONE       = 3'd5
   } bmag_state_e;

   localparam int unsigned SEL_W = 5;

   localparam logic [SEL_W-1:0] SEL_MM_RD  = 5'h10;
   localparam logic [SEL_W-1:0] SEL_MM_WR  = 5'h11;
   localparam logic [SEL_W-1:0] SEL_FETCH  = 5'h12;
   localparam logic [SEL_W-1:0] SEL_DSAREL = 5'h13;
   localparam logic [SEL_W-1:0] SEL_STATIC = 5'h14;
   localparam logic [SEL_W-1:0] SEL_DYN    = 5'h15;

endpackage

// File: rtl/bmag_tbl_addr.sv
module bmag_tbl_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFS_W = 24
) (
   input  logic [AW-1:0]    base,
   input  logic [OFS_W-1:0] ofs,
   output logic [AW-1:0]    tbl_addr
);
   localparam int unsigned EXT_W = AW - OFS_W;

   logic [AW-1:0] ofs_ext;

   assign ofs_ext  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
   assign tbl_addr = base + ofs_ext;
endmodule

// File: rtl/bmag_hi_sel.sv
module bmag_hi_sel
   import bmag_pkg::*;
#(
   parameter int unsigned DW   = 32,
   parameter int unsigned NSCR = 16
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [NSCR*DW-1:0] scratch_vec,
   input  logic [DW-1:0]      mm_rd,
   input  logic [DW-1:0]      mm_wr,
   input  logic [DW-1:0]      fetch,
   input  logic [DW-1:0]      dsarel,
   input  logic [DW-1:0]      stat,
   input  logic [DW-1:0]      dyn,
   output logic [DW-1:0]      hi,
   output logic               bad
);
   localparam int unsigned IW = (NSCR > 1) ? $clog2(NSCR) : 1;

   logic [DW-1:0] scr [NSCR];

   generate
      for (genvar g = 0; g < NSCR; g++) begin : g_unpack
         assign scr[g] = scratch_vec[g*DW +: DW];
      end
   endgenerate

   always_comb begin
      hi  = '0;
      bad = 1'b0;
      if (32'(sel) < NSCR) begin
         hi = scr[sel[IW-1:0]];
      end else begin
         case (sel)
            SEL_MM_RD:  hi = mm_rd;
            SEL_MM_WR:  hi = mm_wr;
            SEL_FETCH:  hi = fetch;
            SEL_DSAREL: hi = dsarel;
            SEL_STATIC: hi = stat;
            SEL_DYN:    hi = dyn;
            default:    bad = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/bmag_seq.sv
module bmag_seq
   import bmag_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned CNT_W   = 24,
   parameter int unsigned TBL_BIT = 28,
   parameter int unsigned IND_BIT = 29
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [AW-1:0]       w0,
   input  logic [AW-1:0]       w1,
   input  logic [AW-1:0]       ptr_in,
   input  logic [AW-1:0]       tbl_addr,
   input  logic                m40,
   input  logic                mti,
   input  logic                md64,
   output logic                mem_req,
   output logic [AW-1:0]       mem_addr,
   input  logic                mem_valid,
   input  logic [AW-1:0]       mem_data,
   output logic                busy,
   output logic                fin,
   output logic [CNT_W-1:0]    cnt_q,
   output logic [AW-1:0]       lo_q,
   output logic [AW-CNT_W-1:0] raw_q,
   output logic [AW-1:0]       ptr_q,
   output logic [AW-1:0]       dyn_q,
   output logic                tbl_q,
   output logic                hi_fetched_q,
   output logic                m40_q,
   output logic                mti_q
);
   localparam int unsigned HW = AW - CNT_W;

   bmag_state_e st;

   assign busy    = (st != ST_IDLE);
   assign fin     = (st == ST_DONE);
   assign mem_req = (st == ST_FETCH_PTR) || (st == ST_FETCH_TBL0) ||
                    (st == ST_FETCH_TBL1) || (st == ST_FETCH_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         mem_addr     <= '0;
         cnt_q        <= '0;
         lo_q         <= '0;
         raw_q        <= '0;
         ptr_q        <= '0;
         dyn_q        <= '0;
         tbl_q        <= 1'b0;
         hi_fetched_q <= 1'b0;
         m40_q        <= 1'b0;
         mti_q        <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  cnt_q        <= w0[CNT_W-1:0];
                  lo_q         <= w1;
                  raw_q        <= '0;
                  ptr_q        <= ptr_in;
                  tbl_q        <= w0[TBL_BIT];
                  hi_fetched_q <= 1'b0;
                  m40_q        <= m40;
                  mti_q        <= mti;
                  if (w0[TBL_BIT]) begin
                     mem_addr <= tbl_addr;
                     st       <= ST_FETCH_TBL0;
                  end else if (w0[IND_BIT]) begin
                     mem_addr <= w1;
                     st       <= ST_FETCH_PTR;
                  end else if (md64) begin
                     mem_addr <= ptr_in;
                     st       <= ST_FETCH_HI;
                  end else begin
                     st       <= ST_DONE;
                  end
               end
            end
            ST_FETCH_PTR: begin
               if (mem_valid) begin
                  lo_q <= mem_data;
                  st   <= ST_DONE;
               end
            end
            ST_FETCH_TBL0: begin
               if (mem_valid) begin
                  cnt_q    <= mem_data[CNT_W-1:0];
                  raw_q    <= mem_data[AW-1 -: HW];
                  mem_addr <= mem_addr + AW'(4);
                  st       <= ST_FETCH_TBL1;
               end
            end
            ST_FETCH_TBL1: begin
               if (mem_valid) begin
                  lo_q <= mem_data;
                  st   <= ST_DONE;
               end
            end
            ST_FETCH_HI: begin
               if (mem_valid) begin
                  dyn_q        <= mem_data;
                  ptr_q        <= ptr_q + AW'(4);
                  hi_fetched_q <= 1'b1;
                  st           <= ST_DONE;
               end
            end
            default: begin
               st <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/bmove_addr_gen.sv
module bmove_addr_gen
   import bmag_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned CNT_W   = 24,
   parameter int unsigned NSCR    = 16,
   parameter int unsigned TBL_BIT = 28,
   parameter int unsigned IND_BIT = 29,
   parameter bit          TI64_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [AW-1:0]        instr_w0,
   input  logic [AW-1:0]        instr_w1,
   input  logic [AW-1:0]        script_ptr_in,
   input  logic [AW-1:0]        dsa_base,
   input  logic                 mode_40,
   input  logic                 mode_ti64,
   input  logic                 mode_d64,
   input  logic [NSCR*AW-1:0]   scratch_vec,
   input  logic [AW-1:0]        mm_rd_sel,
   input  logic [AW-1:0]        mm_wr_sel,
   input  logic [AW-1:0]        fetch_sel,
   input  logic [AW-1:0]        dsa_rel_sel,
   input  logic [AW-1:0]        static_sel,
   output logic                 mem_req,
   output logic [AW-1:0]        mem_addr,
   input  logic                 mem_valid,
   input  logic [AW-1:0]        mem_data,
   output logic                 busy,
   output logic                 done,
   output logic [CNT_W-1:0]     xfer_count,
   output logic [2*AW-1:0]      dma_addr,
   output logic [AW-1:0]        instr_addr,
   output logic [AW-1:0]        script_ptr_out,
   output logic [AW-1:0]        dyn_sel,
   output logic                 sel_err
);
   localparam int unsigned HW       = AW - CNT_W;
   localparam int unsigned IA_SHORT = 8;
   localparam int unsigned IA_LONG  = 12;

   generate
      if (CNT_W >= AW)            begin : g_chk_cnt  $error("count must be narrower than the word"); end
      if (HW < SEL_W)             begin : g_chk_hw   $error("table high field narrower than selector"); end
      if (NSCR < 1 || NSCR > 16)  begin : g_chk_nscr $error("scratch count out of range"); end
      if (TBL_BIT == IND_BIT)     begin : g_chk_bits $error("form flag bits must differ"); end
      if (TBL_BIT < CNT_W || IND_BIT < CNT_W || TBL_BIT >= AW || IND_BIT >= AW)
                                  begin : g_chk_pos  $error("form flag bits overlap the count"); end
   endgenerate

   logic [AW-1:0]    tbl_addr;
   logic             fin;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    lo_q;
   logic [HW-1:0]    raw_q;
   logic [AW-1:0]    ptr_q;
   logic             tbl_q;
   logic             hi_fetched_q;
   logic             m40_q;
   logic             mti_q;
   logic [AW-1:0]    sel_hi;
   logic             sel_bad;
   logic             ti_on;
   logic [AW-1:0]    hi_nxt;
   logic             bad_nxt;

   bmag_tbl_addr #(.AW(AW), .OFS_W(CNT_W)) u_tbl (
      .base     (dsa_base),
      .ofs      (instr_w1[CNT_W-1:0]),
      .tbl_addr (tbl_addr)
   );

   bmag_seq #(.AW(AW), .CNT_W(CNT_W), .TBL_BIT(TBL_BIT), .IND_BIT(IND_BIT)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .w0           (instr_w0),
      .w1           (instr_w1),
      .ptr_in       (script_ptr_in),
      .tbl_addr     (tbl_addr),
      .m40          (mode_40),
      .mti          (mode_ti64),
      .md64         (mode_d64),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .mem_valid    (mem_valid),
      .mem_data     (mem_data),
      .busy         (busy),
      .fin          (fin),
      .cnt_q        (cnt_q),
      .lo_q         (lo_q),
      .raw_q        (raw_q),
      .ptr_q        (ptr_q),
      .dyn_q        (dyn_sel),
      .tbl_q        (tbl_q),
      .hi_fetched_q (hi_fetched_q),
      .m40_q        (m40_q),
      .mti_q        (mti_q)
   );

   generate
      if (TI64_EN) begin : g_ti64
         bmag_hi_sel #(.DW(AW), .NSCR(NSCR)) u_hisel (
            .sel         (raw_q[SEL_W-1:0]),
            .scratch_vec (scratch_vec),
            .mm_rd       (mm_rd_sel),
            .mm_wr       (mm_wr_sel),
            .fetch       (fetch_sel),
            .dsarel      (dsa_rel_sel),
            .stat        (static_sel),
            .dyn         (dyn_sel),
            .hi          (sel_hi),
            .bad         (sel_bad)
         );
         assign ti_on = mti_q;
      end else begin : g_no_ti64
         assign sel_hi  = '0;
         assign sel_bad = 1'b0;
         assign ti_on   = 1'b0;
      end
   endgenerate

   always_comb begin
      hi_nxt  = '0;
      bad_nxt = 1'b0;
      if (tbl_q && m40_q) begin
         hi_nxt = AW'(raw_q);
      end else if (tbl_q && ti_on) begin
         hi_nxt  = sel_bad ? '0 : sel_hi;
         bad_nxt = sel_bad;
      end else if (m40_q || ti_on) begin
         hi_nxt = '0;
      end else if (dyn_sel != '0) begin
         hi_nxt = dyn_sel;
      end else if (static_sel != '0) begin
         hi_nxt = static_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done           <= 1'b0;
         xfer_count     <= '0;
         dma_addr       <= '0;
         instr_addr     <= '0;
         script_ptr_out <= '0;
         sel_err        <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sel_err <= 1'b0;
         end
         if (fin) begin
            done           <= 1'b1;
            xfer_count     <= cnt_q;
            dma_addr       <= {hi_nxt, lo_q};
            script_ptr_out <= ptr_q;
            instr_addr     <= ptr_q - (hi_fetched_q ? AW'(IA_LONG) : AW'(IA_SHORT));
            sel_err        <= bad_nxt;
         end
      end
   end
endmodule

// File: rtl/bmag_chk.sv
module bmag_chk #(
   parameter int unsigned AW    = 32,
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             mem_req,
   input logic             mem_valid,
   input logic [AW-1:0]    mem_addr,
   input logic [CNT_W-1:0] xfer_count,
   input logic [2*AW-1:0]  dma_addr,
   input logic [AW-1:0]    instr_addr,
   input logic [AW-1:0]    script_ptr_out,
   input logic             sel_err
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R11

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R11

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R11

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(dma_addr) && $stable(xfer_count) &&
                 $stable(instr_addr) && $stable(script_ptr_out))); // R12

   AST_ERR_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sel_err) |-> (dma_addr[2*AW-1:AW] == '0)); // R7

   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !sel_err); // R7

   AST_IADDR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((script_ptr_out - instr_addr == AW'(8)) ||
                (script_ptr_out - instr_addr == AW'(12)))); // R8
endmodule

bind bmove_addr_gen bmag_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start          (start),
   .busy           (busy),
   .done           (done),
   .mem_req        (mem_req),
   .mem_valid      (mem_valid),
   .mem_addr       (mem_addr),
   .xfer_count     (xfer_count),
   .dma_addr       (dma_addr),
   .instr_addr     (instr_addr),
   .script_ptr_out (script_ptr_out),
   .sel_err        (sel_err)
);

// File: tb/tb_bmove_addr_gen.sv
module tb_bmove_addr_gen;
   localparam int unsigned AW = 32;
   localparam int unsigned CW = 24;
   localparam int unsigned NS = 16;

   localparam logic [31:0] V_MRD = 32'h0000_A010;
   localparam logic [31:0] V_MWR = 32'h0000_A011;
   localparam logic [31:0] V_FCH = 32'h0000_A012;
   localparam logic [31:0] V_DSR = 32'h0000_A013;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [AW-1:0]    instr_w0 = '0, instr_w1 = '0, script_ptr_in = '0, dsa_base = '0;
   logic             mode_40 = 1'b0, mode_ti64 = 1'b0, mode_d64 = 1'b0;
   logic [NS*AW-1:0] scratch_vec;
   logic [AW-1:0]    static_sel = '0;
   logic             mem_req;
   logic [AW-1:0]    mem_addr;
   logic             mem_valid = 1'b0;
   logic [AW-1:0]    mem_data = '0;
   logic             busy, done, sel_err;
   logic [CW-1:0]    xfer_count;
   logic [2*AW-1:0]  dma_addr;
   logic [AW-1:0]    instr_addr, script_ptr_out, dyn_sel;

   int tests = 0;
   int fails = 0;
   int nreads = 0;
   int lat = 0;
   int lat_cnt = 0;
   logic [31:0] mdyn = '0;
   logic [31:0] la [3];
   logic [31:0] ld [3];

   function automatic logic [31:0] scr_val(input int i);
      return 32'h5C00_0000 + 32'(i) * 32'h0001_0111;
   endfunction

   generate
      for (genvar g = 0; g < NS; g++) begin : g_scr
         assign scratch_vec[g*AW +: AW] = scr_val(g);
      end
   endgenerate

   bmove_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .instr_w0(instr_w0), .instr_w1(instr_w1), .script_ptr_in(script_ptr_in),
      .dsa_base(dsa_base), .mode_40(mode_40), .mode_ti64(mode_ti64), .mode_d64(mode_d64),
      .scratch_vec(scratch_vec), .mm_rd_sel(V_MRD), .mm_wr_sel(V_MWR),
      .fetch_sel(V_FCH), .dsa_rel_sel(V_DSR), .static_sel(static_sel),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
      .busy(busy), .done(done), .xfer_count(xfer_count), .dma_addr(dma_addr),
      .instr_addr(instr_addr), .script_ptr_out(script_ptr_out), .dyn_sel(dyn_sel),
      .sel_err(sel_err)
   );

   function automatic logic [31:0] lut(input logic [31:0] a);
      for (int i = 0; i < 3; i++) if (la[i] == a) return ld[i];
      return 32'hBAD0_0000 ^ a;
   endfunction

   // memory responder: one response per request, after lat idle negedges
   always @(negedge clk) begin
      if (mem_valid) begin
         mem_valid = 1'b0;
         lat_cnt   = 0;
      end else if (mem_req) begin
         if (lat_cnt >= lat) begin
            mem_valid = 1'b1;
            mem_data  = lut(mem_addr);
            nreads++;
            lat_cnt   = 0;
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run(input string rq, input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] ptr, input logic [31:0] dsa,
                      input logic m40, input logic mti, input logic md, input int lat_v);
      logic        tb, ind, dh;
      logic [31:0] ta, c0, e_lo, e_hi, e_ptr, e_ia, hold_ia;
      logic [23:0] e_cnt;
      logic [7:0]  raw;
      logic        e_err;
      int          e_reads, n, s;
      logic [63:0] hold_addr;
      logic [31:0] spec [6];
      tb = w0[28];
      ind = !tb && w0[29];
      dh = !tb && !ind && md;
      e_cnt = w0[23:0]; e_lo = w1; raw = '0; e_reads = 0; e_ptr = ptr; e_err = 1'b0;
      if (tb) begin
         ta = dsa + {{8{w1[23]}}, w1[23:0]};
         c0 = lut(ta);
         e_cnt = c0[23:0];
         raw = c0[31:24];
         e_lo = lut(ta + 32'd4);
         e_reads = 2;
      end else if (ind) begin
         e_lo = lut(w1);
         e_reads = 1;
      end else if (dh) begin
         mdyn = lut(ptr);
         e_ptr = ptr + 32'd4;
         e_reads = 1;
      end
      e_ia = dh ? e_ptr - 32'd12 : ptr - 32'd8;
      spec[0] = V_MRD; spec[1] = V_MWR; spec[2] = V_FCH;
      spec[3] = V_DSR; spec[4] = static_sel; spec[5] = mdyn;
      e_hi = '0;
      if (tb && m40) e_hi = {24'h0, raw};
      else if (tb && mti) begin
         s = int'(raw[4:0]);
         if (s < 16) e_hi = scr_val(s);
         else if (s < 22) e_hi = spec[s-16];
         else e_err = 1'b1;
      end else if (m40 || mti) e_hi = '0;
      else if (mdyn != 0) e_hi = mdyn;
      else if (static_sel != 0) e_hi = static_sel;

      @(negedge clk);
      instr_w0 = w0; instr_w1 = w1; script_ptr_in = ptr; dsa_base = dsa;
      mode_40 = m40; mode_ti64 = mti; mode_d64 = md;
      lat = lat_v; nreads = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      if (!done) begin
         chk("R11", "completion timeout", 64'(n), 64'(0));
      end else begin
         chk("R1", "count", 64'(xfer_count), 64'(e_cnt));
         chk(rq, "address", dma_addr, {e_hi, e_lo});
         chk(dh ? "R8" : "R9", "ptr", 64'(script_ptr_out), 64'(e_ptr));
         chk(dh ? "R8" : "R9", "iaddr", 64'(instr_addr), 64'(e_ia));
         chk("R7", "err", 64'(sel_err), 64'(e_err));
         chk("R11", "reads", 64'(nreads), 64'(e_reads));
         chk("R8", "dyn_sel", 64'(dyn_sel), 64'(mdyn));
         hold_addr = dma_addr; hold_ia = instr_addr;
         instr_w1 = ~w1; script_ptr_in = ~ptr; mode_40 = ~m40;
         repeat (3) @(negedge clk);
         chk("R12", "held addr/done", {hold_addr[62:0], done}, {dma_addr[62:0], 1'b0});
         chk("R12", "held iaddr", 64'(instr_addr), 64'(hold_ia));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) begin la[i] = 32'hFFFF_FFF0 + 32'(i); ld[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R12", "reset addr", dma_addr, 64'h0);
      chk("R12", "reset misc", {27'h0, done, busy, sel_err, mem_req, 1'b0, 32'h0},
          {27'h0, 5'h0, dyn_sel});
      rst_n = 1'b1;
      @(negedge clk);

      // R2 direct, fallback zero
      run("R2", 32'h0100_0040, 32'h1234_5678, 32'h0000_1008, 32'h0, 0, 0, 0, 0);
      // R10 static fallback
      static_sel = 32'h0000_0077;
      run("R10", 32'h0000_0200, 32'h0ABC_0000, 32'h0000_2008, 32'h0, 0, 0, 0, 0);
      // R3 indirect
      la[0] = 32'h0000_3000; ld[0] = 32'hCAFE_F00D;
      run("R3", 32'h2000_0010, 32'h0000_3000, 32'h0000_3108, 32'h0, 0, 0, 0, 2);
      // R4 table, positive offset, junk in high count bits
      la[0] = 32'h0001_0040; ld[0] = 32'hEE12_3456;
      la[1] = 32'h0001_0044; ld[1] = 32'h8765_4321;
      run("R4", 32'h1000_0001, 32'h0000_0040, 32'h0000_4008, 32'h0001_0000, 0, 0, 0, 1);
      // R4 table, negative offset, with bit 29 and d64 also set
      la[0] = 32'h0001_FFF0; ld[0] = 32'h0000_0100;
      la[1] = 32'h0001_FFF4; ld[1] = 32'h1111_2222;
      run("R4", 32'h3000_0005, 32'h00FF_FFF0, 32'h0000_5008, 32'h0002_0000, 0, 0, 1, 0);
      // R5 40-bit table, and 40-bit beats ti64
      la[0] = 32'h0003_0000; ld[0] = 32'h3F00_0020;
      la[1] = 32'h0003_0004; ld[1] = 32'h4444_0000;
      run("R5", 32'h1000_0000, 32'h0000_0000, 32'h0000_6008, 32'h0003_0000, 1, 0, 0, 0);
      run("R5", 32'h1000_0000, 32'h0000_0000, 32'h0000_6108, 32'h0003_0000, 1, 1, 0, 1);
      // R5 40-bit on non-table form -> zero high word
      run("R5", 32'h0000_0033, 32'h5555_0000, 32'h0000_6208, 32'h0, 1, 0, 0, 0);
      // R8 direct 64: third word fetched, R10 dynamic beats static
      la[2] = 32'h0000_7008; ld[2] = 32'h0000_00D1;
      run("R8", 32'h0000_0044, 32'h6666_0000, 32'h0000_7008, 32'h0, 0, 0, 1, 1);
      // R8 d64 ignored for indirect
      la[0] = 32'h0000_7800; ld[0] = 32'h7777_0000;
      run("R8", 32'h2000_0044, 32'h0000_7800, 32'h0000_7008, 32'h0, 0, 0, 1, 0);
      // R10 dynamic persists over static on plain direct
      run("R10", 32'h0000_0045, 32'h0000_9000, 32'h0000_9008, 32'h0, 0, 0, 0, 0);

      // R6 / R7 full selector sweep in table-64 mode
      for (int s = 0; s < 32; s++) begin
         la[0] = 32'h0004_0000 + 32'(s) * 32'd8;
         ld[0] = {3'b101, 5'(s), 24'h000100 + 24'(s)};
         la[1] = la[0] + 32'd4;
         ld[1] = 32'h7000_0000 + 32'(s);
         run(s > 21 ? "R7" : "R6", 32'h1000_0000, 32'(s) * 32'd8, 32'h0000_A008,
             32'h0004_0000, 0, 1, 0, s % 3);
      end

      // R10 d64 fetch of zero clears dynamic -> static chosen
      la[2] = 32'h0000_B008; ld[2] = 32'h0;
      run("R10", 32'h0000_0001, 32'h0000_B000, 32'h0000_B008, 32'h0, 0, 0, 1, 0);
      static_sel = 32'h0;
      run("R10", 32'h0000_0002, 32'h0000_C000, 32'h0000_C008, 32'h0, 0, 0, 0, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule